// File: doc/BRIEF.md
# Register-Write Interrupt Generator

This block sits next to a small bank of four 32-bit configuration registers and raises a level interrupt when software writes one of the two data registers. It takes its stimulus from a bus write that has already been decoded. That write arrives as a single-cycle strobe, a byte offset, the write word and its byte strobes. The block keeps two state bits. One is an interrupt enable, loaded from a write to the control register. The other is a pending flag, set by data-register writes and cleared by a write-one to the status register.

The interrupt output is the AND of the enable and pending bits, and it is registered. It therefore follows a write on the same clock edge that captures that write. A separate combinational read port returns the control and status words so that software can inspect both bits. Reads never alter state. Bus handshaking, error responses and the contents of the data registers belong to neighbouring logic.

Top module: `regwr_irq_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the enable bit, the pending flag and `irq_o` are cleared. After reset, reading offset 0x00 or 0x04 returns zero.
- R2: A strobed write to offset 0x00 with `wr_be[0]`=1 loads the enable bit from `wr_data[0]`. Bits 31..1 of `wr_data` have no effect.
- R3: A strobed write to offset 0x08 or 0x0C with `wr_be[0]`=1 sets the pending flag, whatever the write data.
- R4: A strobed write to offset 0x04 with `wr_be[0]`=1 clears the pending flag when `wr_data[0]`=1. It leaves the flag unchanged when `wr_data[0]`=0.
- R5: `irq_o` is registered and equals enable AND pending. A write strobed in cycle k is visible on `irq_o` only after the rising edge that ends cycle k.
- R6: A strobed write with `wr_be[0]`=0 changes neither bit, at any offset.
- R7: A strobed write to any offset other than exactly 0x00, 0x04, 0x08 or 0x0C changes neither bit. This includes unaligned offsets and offsets whose low nibble aliases a defined register.
- R8: `rd_data` is combinational from `rd_offset`. Offset 0x04 returns the pending flag in bit 0 and offset 0x00 returns the enable bit in bit 0. All other bits are zero, and every other offset reads as zero. A read has no side effect on either bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | One-cycle strobe of a decoded register write |
| wr_offset | input | OFFS_W (8) | Byte offset of the write |
| wr_data | input | DATA_W (32) | Write word |
| wr_be | input | DATA_W/8 (4) | Byte strobes of the write |
| rd_offset | input | OFFS_W (8) | Byte offset being read |
| rd_data | output | DATA_W (32) | Read word for `rd_offset` |
| irq_o | output | 1 | Level interrupt, registered |

## Verification
The case hardest to bring about from the ports is a write that looks valid but must not count. Examples are a status write whose clear bit sits in a disabled byte lane, and a control write at an offset such as 0x84 or 0x01, which alias 0x04 or 0x00 in their low bits. To reach these cases, the stimulus table first drives both bits to 1 so that any wrongful change becomes visible. It then applies each near-miss write and reads both bits back through the read port before the next write. A separate directed step checks the exact edge at which `irq_o` moves, and another sweeps every read offset while the pending flag is set, to confirm that reads change nothing.

// File: rtl/regwr_irq_pkg.sv
package regwr_irq_pkg;

    localparam int OFFS_W_DEF = 8;
    localparam int DATA_W_DEF = 32;

    localparam int CTRL_OFS = 'h00;
    localparam int STAT_OFS = 'h04;
    localparam int DAT0_OFS = 'h08;
    localparam int DAT1_OFS = 'h0C;

    typedef enum logic [2:0] {
        SEL_CTRL = 3'd0,
        SEL_STAT = 3'd1,
        SEL_DAT0 = 3'd2,
        SEL_DAT1 = 3'd3,
        SEL_NONE = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic en;
        logic pend;
    } irq_state_t;

    function automatic logic is_data_sel(input reg_sel_e sel);
        return (sel == SEL_DAT0) || (sel == SEL_DAT1);
    endfunction

endpackage

// File: rtl/regwr_irq_decode.sv
module regwr_irq_decode
    import regwr_irq_pkg::*;
#(
    parameter int OFFS_W = OFFS_W_DEF
) (
    input  logic [OFFS_W-1:0] offset,
    output reg_sel_e          sel
);
    localparam logic [OFFS_W-1:0] CTRL_A = OFFS_W'(CTRL_OFS);
    localparam logic [OFFS_W-1:0] STAT_A = OFFS_W'(STAT_OFS);
    localparam logic [OFFS_W-1:0] DAT0_A = OFFS_W'(DAT0_OFS);
    localparam logic [OFFS_W-1:0] DAT1_A = OFFS_W'(DAT1_OFS);

    always_comb begin
        if (offset == CTRL_A)      sel = SEL_CTRL;
        else if (offset == STAT_A) sel = SEL_STAT;
        else if (offset == DAT0_A) sel = SEL_DAT0;
        else if (offset == DAT1_A) sel = SEL_DAT1;
        else                       sel = SEL_NONE;
    end
endmodule

// File: rtl/regwr_irq_flags.sv
module regwr_irq_flags
    import regwr_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_stb,
    input  reg_sel_e   wr_sel,
    input  logic       wr_bit0,
    input  logic       wr_lane0,
    output irq_state_t state_q,
    output logic       irq_q
);
    irq_state_t state_n;

    always_comb begin
        state_n = state_q;
        if (wr_stb && wr_lane0) begin
            if (wr_sel == SEL_CTRL) state_n.en = wr_bit0;
            if (wr_sel == SEL_STAT && wr_bit0) state_n.pend = 1'b0;
            if (is_data_sel(wr_sel)) state_n.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            irq_q   <= state_n.en & state_n.pend;
        end
    end
endmodule

// File: rtl/regwr_irq_rdmux.sv
module regwr_irq_rdmux
    import regwr_irq_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF
) (
    input  reg_sel_e          rd_sel,
    input  irq_state_t        state,
    output logic [DATA_W-1:0] rd_word
);
    always_comb begin
        rd_word = '0;
        case (rd_sel)
            SEL_CTRL: rd_word[0] = state.en;
            SEL_STAT: rd_word[0] = state.pend;
            default:  rd_word    = '0;
        endcase
    end
endmodule

// File: rtl/regwr_irq_gen.sv
module regwr_irq_gen
    import regwr_irq_pkg::*;
#(
    parameter int OFFS_W = OFFS_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_stb,
    input  logic [OFFS_W-1:0]     wr_offset,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [DATA_W/8-1:0]   wr_be,
    input  logic [OFFS_W-1:0]     rd_offset,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  irq_o
);
    localparam int BE_W = DATA_W / 8;

    reg_sel_e   wr_sel;
    reg_sel_e   rd_sel;
    irq_state_t state_q;
    logic       en_q;
    logic       pend_q;
    logic       unused_hi;

    assign unused_hi = ^{wr_data[DATA_W-1:1], wr_be[BE_W-1:1]};

    regwr_irq_decode #(.OFFS_W(OFFS_W)) wr_dec_i (
        .offset (wr_offset),
        .sel    (wr_sel)
    );

    regwr_irq_decode #(.OFFS_W(OFFS_W)) rd_dec_i (
        .offset (rd_offset),
        .sel    (rd_sel)
    );

    regwr_irq_flags flags_i (
        .clk      (clk),
        .rst      (rst),
        .wr_stb   (wr_stb),
        .wr_sel   (wr_sel),
        .wr_bit0  (wr_data[0]),
        .wr_lane0 (wr_be[0]),
        .state_q  (state_q),
        .irq_q    (irq_o)
    );

    regwr_irq_rdmux #(.DATA_W(DATA_W)) rdmux_i (
        .rd_sel  (rd_sel),
        .state   (state_q),
        .rd_word (rd_data)
    );

    assign en_q   = state_q.en;
    assign pend_q = state_q.pend;
endmodule

// File: rtl/regwr_irq_gen_chk.sv
module regwr_irq_gen_chk #(
    parameter int OFFS_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_stb,
    input logic [OFFS_W-1:0] wr_offset,
    input logic              wr_bit0,
    input logic              wr_lane0,
    input logic [OFFS_W-1:0] rd_offset,
    input logic [DATA_W-1:0] rd_data,
    input logic              en_q,
    input logic              pend_q,
    input logic              irq_o
);
    logic defined_ofs;
    assign defined_ofs = (wr_offset == OFFS_W'(8'h00)) || (wr_offset == OFFS_W'(8'h04)) ||
                         (wr_offset == OFFS_W'(8'h08)) || (wr_offset == OFFS_W'(8'h0C));

    AST_CTRL_LOADS_EN: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_lane0 && wr_offset == OFFS_W'(8'h00)) |=> (en_q == $past(wr_bit0))); // R2
    AST_DATA_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_lane0 && (wr_offset == OFFS_W'(8'h08) || wr_offset == OFFS_W'(8'h0C))) |=> pend_q); // R3
    AST_STAT_W1C: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_lane0 && wr_bit0 && wr_offset == OFFS_W'(8'h04)) |=> !pend_q); // R4
    AST_IRQ_IS_AND: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == (en_q && pend_q))); // R5
    AST_LANE0_GATES: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !wr_lane0) |=> ($stable(en_q) && $stable(pend_q))); // R6
    AST_UNDEF_OFS_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !defined_ofs) |=> ($stable(en_q) && $stable(pend_q))); // R7
    AST_STATUS_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_offset == OFFS_W'(8'h04)) |-> (rd_data == DATA_W'(pend_q))); // R8
    AST_NO_WRITE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> ($stable(en_q) && $stable(pend_q))); // R8
endmodule

bind regwr_irq_gen regwr_irq_gen_chk #(.OFFS_W(OFFS_W), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .wr_stb    (wr_stb),
    .wr_offset (wr_offset),
    .wr_bit0   (wr_data[0]),
    .wr_lane0  (wr_be[0]),
    .rd_offset (rd_offset),
    .rd_data   (rd_data),
    .en_q      (en_q),
    .pend_q    (pend_q),
    .irq_o     (irq_o)
);

// File: tb/regwr_irq_gen_tb_top.sv
module regwr_irq_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_stb = 1'b0;
    logic [7:0]  wr_offset = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_be = '0;
    logic [7:0]  rd_offset = '0;
    logic [31:0] rd_data;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    regwr_irq_gen dut_i (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_offset(wr_offset),
        .wr_data(wr_data), .wr_be(wr_be), .rd_offset(rd_offset),
        .rd_data(rd_data), .irq_o(irq_o)
    );

    typedef struct packed {
        logic [7:0]  ofs;
        logic [31:0] data;
        logic [3:0]  be;
        logic        exp_en;
        logic        exp_pend;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 32'h0000_0001, 4'hF, 1'b1, 1'b0, 8'd2}, // R2 enable on
        '{8'h08, 32'h0000_0000, 4'hF, 1'b1, 1'b1, 8'd3}, // R3 data0 sets, data ignored
        '{8'h04, 32'h0000_0000, 4'hF, 1'b1, 1'b1, 8'd4}, // R4 write zero keeps
        '{8'h04, 32'hFFFF_FFFE, 4'hF, 1'b1, 1'b1, 8'd4}, // R4 upper ones ignored
        '{8'h04, 32'h0000_0001, 4'hF, 1'b1, 1'b0, 8'd4}, // R4 clear
        '{8'h0C, 32'h1234_5678, 4'hF, 1'b1, 1'b1, 8'd3}, // R3 data1 sets
        '{8'h04, 32'h0000_0001, 4'hE, 1'b1, 1'b1, 8'd6}, // R6 lane 0 off, no clear
        '{8'h00, 32'h0000_0000, 4'hE, 1'b1, 1'b1, 8'd6}, // R6 lane 0 off, no disable
        '{8'h84, 32'h0000_0001, 4'hF, 1'b1, 1'b1, 8'd7}, // R7 alias of status
        '{8'h80, 32'h0000_0000, 4'hF, 1'b1, 1'b1, 8'd7}, // R7 alias of control
        '{8'h01, 32'h0000_0000, 4'hF, 1'b1, 1'b1, 8'd7}, // R7 unaligned
        '{8'h10, 32'h0000_0000, 4'hF, 1'b1, 1'b1, 8'd7}, // R7 past the bank
        '{8'h00, 32'hFFFF_FFFE, 4'hF, 1'b0, 1'b1, 8'd2}, // R2 bit 0 only
        '{8'h04, 32'h0000_0001, 4'hF, 1'b0, 1'b0, 8'd4}, // R4 clear while disabled
        '{8'h08, 32'h0000_0000, 4'hE, 1'b0, 1'b0, 8'd6}, // R6 data write lane off
        '{8'h08, 32'h0000_0000, 4'h1, 1'b0, 1'b1, 8'd3}, // R3 lane 0 alone suffices
        '{8'h00, 32'h0000_0001, 4'h1, 1'b1, 1'b1, 8'd5}  // R5 enable raises irq
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic read_word(input logic [7:0] ofs, output logic [31:0] val);
        rd_offset = ofs;
        #1;
        val = rd_data;
    endtask

    task automatic do_write(input logic [7:0] ofs, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        wr_stb = 1'b1; wr_offset = ofs; wr_data = d; wr_be = be;
        @(negedge clk);
        wr_stb = 1'b0; wr_offset = '0; wr_data = '0; wr_be = '0;
    endtask

    task automatic check_state(input string tag, input logic e, input logic p);
        logic [31:0] v;
        read_word(8'h04, v);
        check({tag, " status"}, v, {31'd0, p});
        read_word(8'h00, v);
        check({tag, " control"}, v, {31'd0, e});
        check({tag, " irq"}, {31'd0, irq_o}, {31'd0, e & p});
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_state("R1 reset", 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            do_write(VECS[i].ofs, VECS[i].data, VECS[i].be);
            check_state($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].exp_en, VECS[i].exp_pend);
        end

        // R5: edge at which irq moves (en=1, pend=1 now)
        @(negedge clk);
        wr_stb = 1'b1; wr_offset = 8'h04; wr_data = 32'h1; wr_be = 4'hF;
        #1 check("R5 irq before edge", {31'd0, irq_o}, 32'd1);
        @(posedge clk); #1;
        wr_stb = 1'b0; wr_be = '0; wr_data = '0;
        check("R5 irq after edge", {31'd0, irq_o}, 32'd0);
        @(negedge clk);
        wr_stb = 1'b1; wr_offset = 8'h0C; wr_data = 32'h0; wr_be = 4'hF;
        #1 check("R5 irq before set edge", {31'd0, irq_o}, 32'd0);
        @(posedge clk); #1;
        wr_stb = 1'b0; wr_be = '0;
        check("R5 irq after set edge", {31'd0, irq_o}, 32'd1);

        // R8: sweep reads, nothing changes, unused offsets read zero
        @(negedge clk);
        for (int k = 0; k < 256; k++) begin
            read_word(k[7:0], v);
            if (k != 0 && k != 4) check("R8 other offset reads zero", v, 32'd0);
        end
        repeat (2) @(negedge clk);
        check_state("R8 after read sweep", 1'b1, 1'b1);

        // R1: reset mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_state("R1 mid-run reset", 1'b0, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule